// File: doc/BRIEF.md
# Memory-Fed Sample Waveform Player

This block replays a waveform held in a shared, word-wide memory onto an 8-bit parallel output that feeds a DAC. Software programs one configuration word through a small bus-slave port: the sample spacing in clock cycles, the highest memory word address that belongs to the waveform, and a run enable.

While running, the block acts as a bus master with a Wishbone-style read handshake and fetches one 32-bit word at a time, starting at word address 0. Each word carries four 8-bit samples. They are shown one after another on the output, each for the programmed number of cycles. The next word is requested only once the final sample of the current word has had its full display time. After the end address the read address returns to 0, so the waveform loops for as long as run stays set.

Top module: `wave_player`

## Requirements
- R1: The configuration register answers at address BASE_ADDR (default 0x3000_0000) and acknowledges one cycle after cyc and stb appear. A write takes bits 15:0 as the period, bits 23:16 as the end word address and bit 24 as run. A read returns these fields in the same positions, with bits 31:25 reading as zero.
- R2: After reset the output is 0, no memory request is pending, and the configuration register reads as zero.
- R3: In the cycle after the write that sets run, a read request for word address 0 is presented.
- R4: A memory request keeps cyc, stb and the address steady until ack arrives. The data is taken on the ack cycle, and cyc falls in the cycle after that.
- R5: Samples leave a word lowest byte first: bits 7:0, then 15:8, 23:16 and 31:24. Bits 7:0 appear on the output in the cycle right after the acknowledge.
- R6: Each sample stays on the output for exactly P cycles, where P is the period field and a period of 0 counts as 1.
- R7: No request is made while a word is still being played. The next request starts in the cycle right after the fourth sample has been shown for P cycles.
- R8: Word addresses count up from 0 and go back to 0 after the word at the end address, so playback repeats.
- R9: While run is low, no request is made, the output keeps its last value, and the next run starts again from word 0, byte 0. Clearing run during a request withdraws it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sCyc | input | 1 | Config slave cycle valid |
| sStb | input | 1 | Config slave strobe |
| sWe | input | 1 | Config slave write enable |
| sAdr | input | 32 | Config slave byte address |
| sDatW | input | 32 | Config slave write data |
| sDatR | output | 32 | Config slave read data |
| sAck | output | 1 | Config slave acknowledge |
| mCyc | output | 1 | Memory master cycle |
| mStb | output | 1 | Memory master strobe |
| mAdr | output | 8 | Memory word address |
| mDatR | input | 32 | Memory read data |
| mAck | input | 1 | Memory acknowledge |
| dacOut | output | 8 | Sample output to the DAC |

## Verification
The assertions rely on two conditions. The memory acknowledges only while a request is open, and the end address is never lowered below the current read address while run is set. The stimulus honours both: the memory model raises ack only after it has seen cyc high, and all period and end-address changes are made in the same write that clears or sets run. The sweep covers every pairing of five periods, including 0, with three end addresses. The memory's acknowledge latency changes from word to word, so the request-hold and sample-spacing checks run against several handshake timings.

// File: rtl/wave_pkg.sv
package wave_pkg;
  // strobes from the sequencer to the sample datapath
  typedef struct packed {
    logic loadWord;  // capture fetched word, show its first sample
    logic nextByte;  // advance to the following sample of the word
    logic nextWord;  // word used up: step (or wrap) the read address
    logic clear;     // stopped: rewind address and sample index
  } waveCtl_t;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_PLAY  = 1'b1
  } waveState_t;
endpackage

// File: rtl/wave_cfg_regs.sv
module wave_cfg_regs #(
  parameter int          DATA_W    = 32,
  parameter int          PERIOD_W  = 16,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] BASE_ADDR = 32'h3000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sCyc,
  input  logic                sStb,
  input  logic                sWe,
  input  logic [31:0]         sAdr,
  input  logic [DATA_W-1:0]   sDatW,
  output logic [DATA_W-1:0]   sDatR,
  output logic                sAck,
  output logic [PERIOD_W-1:0] period,
  output logic [ADDR_W-1:0]   endAddr,
  output logic                run
);
  localparam int END_LSB = PERIOD_W;
  localparam int RUN_BIT = PERIOD_W + ADDR_W;

  logic hit;
  logic takeWrite;

  assign hit       = sCyc && sStb && (sAdr == BASE_ADDR);
  assign takeWrite = hit && !sAck && sWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sAck    <= 1'b0;
      period  <= '0;
      endAddr <= '0;
      run     <= 1'b0;
    end else begin
      sAck <= hit && !sAck;
      if (takeWrite) begin
        period  <= sDatW[PERIOD_W-1:0];
        endAddr <= sDatW[END_LSB +: ADDR_W];
        run     <= sDatW[RUN_BIT];
      end
    end
  end

  assign sDatR = DATA_W'({run, endAddr, period});

  generate
    if (RUN_BIT < DATA_W - 1) begin : g_spare
      logic unusedHighBits;
      assign unusedHighBits = ^sDatW[DATA_W-1:RUN_BIT+1];
    end
  endgenerate

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sAck |=> !sAck) else $error("config ack held"); // R1
endmodule

// File: rtl/wave_ctrl.sv
module wave_ctrl
  import wave_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  input  logic                mAck,
  input  logic                lastByte,
  output logic                request,
  output waveCtl_t            ctl
);
  waveState_t          state;
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] limit;
  logic                expire;

  // a period of 0 behaves like 1
  assign limit  = (period == '0) ? PERIOD_W'(0) : period - PERIOD_W'(1);
  assign expire = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      state <= ST_FETCH;
      cnt   <= '0;
    end else begin
      case (state)
        ST_FETCH: begin
          cnt <= '0;
          if (mAck) state <= ST_PLAY;
        end
        default: begin
          if (expire) begin
            cnt <= '0;
            if (lastByte) state <= ST_FETCH;
          end else begin
            cnt <= cnt + PERIOD_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    request      = run && (state == ST_FETCH);
    ctl.clear    = !run;
    ctl.loadWord = request && mAck;
    ctl.nextByte = run && (state == ST_PLAY) && expire && !lastByte;
    ctl.nextWord = run && (state == ST_PLAY) && expire && lastByte;
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (request && !mAck) |=> (request || !run)) else $error("request dropped before ack"); // R4
endmodule

// File: rtl/wave_datapath.sv
module wave_datapath
  import wave_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SAMPLE_W = 8,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  waveCtl_t            ctl,
  input  logic [ADDR_W-1:0]   endAddr,
  input  logic [DATA_W-1:0]   mDatR,
  output logic [ADDR_W-1:0]   mAdr,
  output logic                lastByte,
  output logic [SAMPLE_W-1:0] dacOut
);
  localparam int SAMPLES = DATA_W / SAMPLE_W;
  localparam int IDX_W   = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

  logic [SAMPLES-1:0][SAMPLE_W-1:0] wordQ;
  logic [IDX_W-1:0]                 idx;
  logic [IDX_W-1:0]                 idxNext;
  logic [ADDR_W-1:0]                addr;

  assign idxNext  = idx + IDX_W'(1);
  assign lastByte = (idx == IDX_W'(SAMPLES - 1));
  assign mAdr     = addr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ  <= '0;
      idx    <= '0;
      addr   <= '0;
      dacOut <= '0;
    end else if (ctl.clear) begin
      idx  <= '0;
      addr <= '0;
    end else begin
      if (ctl.loadWord) begin
        wordQ  <= mDatR;
        idx    <= '0;
        dacOut <= mDatR[SAMPLE_W-1:0];
      end
      if (ctl.nextByte) begin
        idx    <= idxNext;
        dacOut <= wordQ[idxNext];
      end
      if (ctl.nextWord) begin
        idx  <= '0;
        addr <= (addr >= endAddr) ? '0 : addr + ADDR_W'(1);
      end
    end
  end

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> $stable(dacOut)) else $error("output moved while stopped"); // R9
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWord |-> (addr <= endAddr)) else $error("fetch beyond end address"); // R8
endmodule

// File: rtl/wave_player.sv
module wave_player
  import wave_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          SAMPLE_W  = 8,
  parameter int          PERIOD_W  = 16,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] BASE_ADDR = 32'h3000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sCyc,
  input  logic                sStb,
  input  logic                sWe,
  input  logic [31:0]         sAdr,
  input  logic [DATA_W-1:0]   sDatW,
  output logic [DATA_W-1:0]   sDatR,
  output logic                sAck,
  output logic                mCyc,
  output logic                mStb,
  output logic [ADDR_W-1:0]   mAdr,
  input  logic [DATA_W-1:0]   mDatR,
  input  logic                mAck,
  output logic [SAMPLE_W-1:0] dacOut
);
  logic [PERIOD_W-1:0] cfgPeriod;
  logic [ADDR_W-1:0]   cfgEnd;
  logic                cfgRun;
  logic                request;
  logic                lastByte;
  waveCtl_t            ctl;

  wave_cfg_regs #(
    .DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) i_cfg (
    .clk(clk), .rstN(rstN), .sCyc(sCyc), .sStb(sStb), .sWe(sWe), .sAdr(sAdr),
    .sDatW(sDatW), .sDatR(sDatR), .sAck(sAck),
    .period(cfgPeriod), .endAddr(cfgEnd), .run(cfgRun)
  );

  wave_ctrl #(.PERIOD_W(PERIOD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .run(cfgRun), .period(cfgPeriod), .mAck(mAck),
    .lastByte(lastByte), .request(request), .ctl(ctl)
  );

  wave_datapath #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .endAddr(cfgEnd), .mDatR(mDatR),
    .mAdr(mAdr), .lastByte(lastByte), .dacOut(dacOut)
  );

  assign mCyc = request;
  assign mStb = request;

  AST_NO_REQ_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRun |-> !mCyc) else $error("request while stopped"); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (mCyc && !mAck) |=> (!mCyc || $stable(mAdr))) else $error("address moved mid-request"); // R4
endmodule

// File: tb/test_wave_player.sv
module test_wave_player;
  localparam logic [31:0] BASE = 32'h3000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sCyc = 1'b0, sStb = 1'b0, sWe = 1'b0;
  logic [31:0] sAdr = '0, sDatW = '0;
  logic [31:0] sDatR;
  logic        sAck;
  logic        mCyc, mStb;
  logic [7:0]  mAdr;
  logic [31:0] mDatR = '0;
  logic        mAck = 1'b0;
  logic [7:0]  dacOut;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  wave_player i_wave_player (
    .clk(clk), .rstN(rstN), .sCyc(sCyc), .sStb(sStb), .sWe(sWe), .sAdr(sAdr),
    .sDatW(sDatW), .sDatR(sDatR), .sAck(sAck), .mCyc(mCyc), .mStb(mStb),
    .mAdr(mAdr), .mDatR(mDatR), .mAck(mAck), .dacOut(dacOut)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] sampleAt(input int a, input int k);
    return 8'((a * 4 + k + 1) & 255);
  endfunction

  function automatic logic [31:0] wordAt(input int a);
    return {sampleAt(a, 3), sampleAt(a, 2), sampleAt(a, 1), sampleAt(a, 0)};
  endfunction

  task automatic cfgWrite(input logic [31:0] d);
    @(negedge clk);
    sCyc = 1'b1; sStb = 1'b1; sWe = 1'b1; sAdr = BASE; sDatW = d;
    @(negedge clk);
    while (!sAck) @(negedge clk);
    sCyc = 1'b0; sStb = 1'b0; sWe = 1'b0;
  endtask

  task automatic cfgRead(output logic [31:0] d);
    @(negedge clk);
    sCyc = 1'b1; sStb = 1'b1; sWe = 1'b0; sAdr = BASE;
    @(negedge clk);
    while (!sAck) @(negedge clk);
    d = sDatR;
    sCyc = 1'b0; sStb = 1'b0;
  endtask

  // entered at a negedge where the request should already be open
  task automatic playWord(input int a, input int pEff, input int lat, input string adrTag);
    chk(mCyc === 1'b1 && mStb === 1'b1, "R7 request open", {mCyc, mStb}, 2'b11);
    chk(mAdr === 8'(a), {adrTag, " word address"}, mAdr, a);
    for (int w = 1; w < lat; w++) begin
      @(negedge clk);
      chk(mCyc === 1'b1 && mAdr === 8'(a), "R4 hold until ack", {mCyc, mAdr}, {1'b1, 8'(a)});
    end
    mAck = 1'b1; mDatR = wordAt(a);
    @(negedge clk);
    mAck = 1'b0; mDatR = '0;
    chk(mCyc === 1'b0, "R4 cyc drops after ack", mCyc, 0);
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < pEff; j++) begin
        if (k != 0 || j != 0) @(negedge clk);
        chk(dacOut === sampleAt(a, k), (k == 0) ? "R5 first sample" : "R6 sample spacing",
            dacOut, sampleAt(a, k));
        chk(mCyc === 1'b0, "R7 no request mid-word", mCyc, 0);
      end
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int periods[5] = '{0, 1, 2, 3, 5};
    int ends[3]    = '{0, 1, 3};
    repeat (3) @(negedge clk);
    chk(dacOut === 8'h00, "R2 output after reset", dacOut, 0);
    chk(mCyc === 1'b0, "R2 no request in reset", mCyc, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(mCyc === 1'b0 && dacOut === 8'h00, "R2 idle after reset", {mCyc, dacOut}, 0);
    cfgRead(rd);
    chk(rd === 32'h0, "R2 config reads zero", rd, 0);

    cfgWrite(32'hFE5A_ABCD);
    cfgRead(rd);
    chk(rd === 32'h005A_ABCD, "R1 readback fields", rd, 32'h005A_ABCD);
    chk(mCyc === 1'b0, "R9 run clear keeps bus quiet", mCyc, 0);

    foreach (periods[pi]) begin
      foreach (ends[ei]) begin
        int p    = periods[pi];
        int e    = ends[ei];
        int pEff = (p == 0) ? 1 : p;
        int nW   = 2 * (e + 1) + 1;
        logic [7:0] lastOut;
        logic [31:0] cfg = {7'd0, 1'b1, 8'(e), 16'(p)};
        cfgWrite(cfg);
        chk(mCyc === 1'b1, "R3 request right after run", mCyc, 1);
        for (int w = 0; w < nW; w++) begin
          playWord(w % (e + 1), pEff, (w % 3) + 1, (w == 0) ? "R3" : "R8");
        end
        chk(mCyc === 1'b1, "R7 next request follows last sample", mCyc, 1);
        lastOut = sampleAt((nW - 1) % (e + 1), 3);
        cfgWrite({7'd0, 1'b0, 8'(e), 16'(p)});
        chk(mCyc === 1'b0, "R9 request withdrawn on stop", mCyc, 0);
        cfgRead(rd);
        chk(rd === {7'd0, 1'b0, 8'(e), 16'(p)}, "R1 readback after stop", rd, {7'd0, 1'b0, 8'(e), 16'(p)});
        for (int h = 0; h < 3; h++) begin
          @(negedge clk);
          chk(dacOut === lastOut && mCyc === 1'b0, "R9 output held while stopped",
              {mCyc, dacOut}, {1'b0, lastOut});
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule